// File: doc/BRIEF.md
# Fine Bin Linearizer

The block corrects the unequal widths of the fine time bins of a time-to-digital converter. A calibration run feeds it hits whose arrival times are random relative to the fine interval. It counts how many of them land in each of the 32 fine codes. Once a fixed total of 2^N hits has been seen, it walks the histogram once and stores, for every fine code, the running sum of the counts of all lower codes. That sum is the lower edge of the code on a scale where the whole interval is 2^N units wide and each ideal bin is 2^N/32 units wide.

After calibration every incoming fine code is placed at a random point inside its measured span: the lower edge plus a random fraction of its width. The ideal bin that contains this point is the corrected code. A narrow code that lies wholly inside one ideal bin therefore always gives that bin. Hits in a wide code are spread over every ideal bin it overlaps, in proportion to the overlap. The random fraction comes from a 16-bit maximal-length shift register that steps once per corrected hit. Until calibration completes, codes pass through unchanged. The output stream keeps the input's one-hit-per-cycle rate and has one cycle of latency.

Top module: `fine_bin_linearizer`

## Requirements
- R1: After reset `cal_done` and `out_valid` are low.
- R2: `out_valid` equals `in_valid` of the previous cycle. While `cal_done` is low, `out_code` equals the previous cycle's `in_code`.
- R3: A `cal_start` pulse drops `cal_done` on the next cycle, clears every bin count and starts a calibration. The calibration accepts exactly 2^N valid hits. After the edge that takes the last hit, `cal_done` rises on the 32nd clock edge, once the edge table has been built.
- R4: The width of code c is the number of calibration hits that carried code c. The lower edge of code c is the sum of the widths of codes 0 to c-1, and the lower edge of code 0 is 0.
- R5: While `cal_done` is high, a valid hit with code c and current random value r gives `out_code = (edge(c) + ((r * width(c)) >> 16)) >> (N - 5)`.
- R6: The random value starts at 0x ACE1 after reset. Each valid hit while `cal_done` is high steps it once by a right shift, XOR-ing 0xB400 into the result when the bit shifted out is 1. Otherwise it holds. It is never zero. Over many hits in a code that spans two ideal bins, both bins occur in roughly equal proportion.
- R7: After a calibration in which every code got 2^N/32 hits, each code maps to itself.
- R8: A code that lies wholly inside one ideal bin always maps to that bin. A code with zero width maps to the ideal bin that contains its lower edge.
- R9: A `cal_start` in the middle of a calibration discards the hits counted so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Pulse that begins a new calibration |
| in_valid | input | 1 | Fine-code hit valid |
| in_code | input | BIN_W (5) | Raw fine code |
| cal_done | output | 1 | Edge table is valid and correction is active |
| out_valid | output | 1 | Corrected-code valid |
| out_code | output | BIN_W (5) | Corrected (or passed-through) fine code |

## Verification
The bound checker watches several rules on every cycle: the one-cycle latency of the valid signal, pass-through before calibration, `cal_done` dropping after a start pulse, and the random source stepping only on corrected hits and never reaching zero. The mapping itself is a different matter. The histogram edges, the identity map for a uniform histogram, single-bin and empty codes, and the dithering share between two ideal bins depend on a whole calibration run. Only the bench scenarios can show them, by comparing the output against a model that computes the edges from its own hit counts and steps its own copy of the shift register.

// File: rtl/fbl_pkg.sv
package fbl_pkg;
    localparam int RND_W = 16;
    localparam logic [RND_W-1:0] RND_SEED = 16'hACE1;
    localparam logic [RND_W-1:0] RND_MASK = 16'hB400;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAL   = 2'd1,
        ST_BUILD = 2'd2,
        ST_DONE  = 2'd3
    } fbl_state_e;
endpackage

// File: rtl/fbl_lfsr.sv
module fbl_lfsr
    import fbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [RND_W-1:0] rnd
);
    logic [RND_W-1:0] rnd_d, rnd_q;

    always_comb begin
        rnd_d = rnd_q;
        if (adv) begin
            rnd_d = (rnd_q >> 1) ^ (rnd_q[0] ? RND_MASK : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rnd_q <= RND_SEED;
        else        rnd_q <= rnd_d;
    end

    assign rnd = rnd_q;
endmodule

// File: rtl/fbl_dither.sv
module fbl_dither
    import fbl_pkg::*;
#(
    parameter int BIN_W = 5,
    parameter int CNT_W = 16,
    parameter int SHIFT = 5
) (
    input  logic [CNT_W-1:0] lo_edge,
    input  logic [CNT_W-1:0] width,
    input  logic [RND_W-1:0] rnd,
    output logic [BIN_W-1:0] bin
);
    localparam int PROD_W = CNT_W + RND_W;

    logic [PROD_W-1:0] prod;
    logic [CNT_W:0]    pos;

    always_comb begin
        prod = {{RND_W{1'b0}}, width} * {{CNT_W{1'b0}}, rnd};
        pos  = {1'b0, lo_edge} + (CNT_W+1)'(prod >> RND_W);
        bin  = BIN_W'(pos >> SHIFT);
    end
endmodule

// File: rtl/fbl_calib.sv
module fbl_calib
    import fbl_pkg::*;
#(
    parameter int BIN_W     = 5,
    parameter int CNT_W     = 16,
    parameter int LOG2_TOTAL = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cal_start,
    input  logic                            hit_valid,
    input  logic [BIN_W-1:0]                hit_code,
    output logic                            done,
    output logic [(1<<BIN_W)-1:0][CNT_W-1:0] widths,
    output logic [(1<<BIN_W)-1:0][CNT_W-1:0] edges
);
    localparam int BINS  = 1 << BIN_W;
    localparam int TOT_W = LOG2_TOTAL;

    typedef struct packed {
        fbl_state_e                  st;
        logic [TOT_W-1:0]            total;
        logic [BIN_W-1:0]            idx;
        logic [CNT_W-1:0]            acc;
        logic [BINS-1:0][CNT_W-1:0]  hist;
        logic [BINS-1:0][CNT_W-1:0]  lo;
    } cal_t;

    cal_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        case (cal_q.st)
            ST_CAL: begin
                if (hit_valid) begin
                    if (cal_q.hist[hit_code] != '1) begin
                        cal_d.hist[hit_code] = cal_q.hist[hit_code] + CNT_W'(1);
                    end
                    if (cal_q.total == '1) begin
                        cal_d.st  = ST_BUILD;
                        cal_d.idx = '0;
                        cal_d.acc = '0;
                    end else begin
                        cal_d.total = cal_q.total + TOT_W'(1);
                    end
                end
            end
            ST_BUILD: begin
                cal_d.lo[cal_q.idx] = cal_q.acc;
                cal_d.acc = cal_q.acc + cal_q.hist[cal_q.idx];
                if (cal_q.idx == BIN_W'(BINS-1)) cal_d.st  = ST_DONE;
                else                             cal_d.idx = cal_q.idx + BIN_W'(1);
            end
            default: ;
        endcase
        if (cal_start) begin
            cal_d.st    = ST_CAL;
            cal_d.total = '0;
            cal_d.hist  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

    assign done   = (cal_q.st == ST_DONE);
    assign widths = cal_q.hist;
    assign edges  = cal_q.lo;
endmodule

// File: rtl/fine_bin_linearizer.sv
module fine_bin_linearizer
    import fbl_pkg::*;
#(
    parameter int BIN_W      = 5,
    parameter int CNT_W      = 16,
    parameter int LOG2_TOTAL = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_start,
    input  logic             in_valid,
    input  logic [BIN_W-1:0] in_code,
    output logic             cal_done,
    output logic             out_valid,
    output logic [BIN_W-1:0] out_code
);
    localparam int BINS  = 1 << BIN_W;
    localparam int SHIFT = LOG2_TOTAL - BIN_W;

    typedef struct packed {
        logic             vld;
        logic [BIN_W-1:0] code;
    } out_t;

    logic [BINS-1:0][CNT_W-1:0] widths;
    logic [BINS-1:0][CNT_W-1:0] edges;
    logic [RND_W-1:0]           rnd;
    logic [BIN_W-1:0]           mapped;
    out_t                       out_d, out_q;

    fbl_calib #(.BIN_W(BIN_W), .CNT_W(CNT_W), .LOG2_TOTAL(LOG2_TOTAL)) u_calib (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_start (cal_start),
        .hit_valid (in_valid),
        .hit_code  (in_code),
        .done      (cal_done),
        .widths    (widths),
        .edges     (edges)
    );

    fbl_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid & cal_done),
        .rnd   (rnd)
    );

    fbl_dither #(.BIN_W(BIN_W), .CNT_W(CNT_W), .SHIFT(SHIFT)) u_dither (
        .lo_edge (edges[in_code]),
        .width   (widths[in_code]),
        .rnd     (rnd),
        .bin     (mapped)
    );

    always_comb begin
        out_d.vld  = in_valid;
        out_d.code = cal_done ? mapped : in_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign out_code  = out_q.code;
endmodule

// File: rtl/fbl_chk.sv
module fbl_chk
    import fbl_pkg::*;
#(
    parameter int BIN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_start,
    input logic             in_valid,
    input logic [BIN_W-1:0] in_code,
    input logic             cal_done,
    input logic             out_valid,
    input logic [BIN_W-1:0] out_code,
    input logic [RND_W-1:0] rnd
);
    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(in_valid) && !$past(cal_done) |-> out_code == $past(in_code));

    // R3
    start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_done);

    // R6
    rnd_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0);

    // R6
    rnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && cal_done) |=> $stable(rnd));

    // R6
    rnd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cal_done |=> rnd != $past(rnd));
endmodule

bind fine_bin_linearizer fbl_chk #(.BIN_W(BIN_W)) u_chk (.*);

// File: tb/fine_bin_linearizer_bench.sv
module fine_bin_linearizer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 10;
    localparam int TOTAL = 1 << N;
    localparam int SH    = N - 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_start = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] in_code = '0;
    logic       cal_done;
    logic       out_valid;
    logic [4:0] out_code;

    int checks = 0;
    int fails = 0;
    int hc[32];
    logic [15:0] lf = 16'hACE1;

    fine_bin_linearizer u_fine_bin_linearizer (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .in_valid(in_valid),
        .in_code(in_code), .cal_done(cal_done), .out_valid(out_valid), .out_code(out_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lf_next(input logic [15:0] l);
        return (l >> 1) ^ (l[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic int model(input int code, input logic [15:0] r);
        int e = 0;
        for (int j = 0; j < code; j++) e += hc[j];
        return ((e + ((int'(r) * hc[code]) >> 16)) >> SH) & 31;
    endfunction

    // one hit, checked one cycle later
    task automatic send(input int code, input int exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_code  = 5'(code);
        @(posedge clk);
        #1;
        chk(out_valid && out_code == 5'(exp), tag, int'(out_code), exp);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        // R3: done drops after start
        chk(!cal_done, "R3 done after start", int'(cal_done), 0);
    endtask

    task automatic calibrate();
        int n = 0;
        pulse_start();
        for (int b = 0; b < 32; b++)
            for (int j = 0; j < hc[b]; j++) begin
                send(b, b, "R2 passthrough during cal");
                if (cal_done) chk(0, "R9 done early", 1, 0);
            end
        while (!cal_done && n < 100) begin
            @(posedge clk);
            #1;
            n++;
        end
        // R3 / R4: table build takes one cycle per code
        chk(n == 32, "R3 build cycles", n, 32);
    endtask

    task automatic corr(input int code, input string tag);
        int e = model(code, lf);
        send(code, e, tag);
        lf = lf_next(lf);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1
        chk(!cal_done, "R1 done reset", int'(cal_done), 0);
        chk(!out_valid, "R1 valid reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle pass-through and valid latency
        send(19, 19, "R2 idle passthrough");
        send(3, 3, "R2 idle passthrough");
        @(posedge clk);
        #1;
        chk(!out_valid, "R2 valid low", int'(out_valid), 0);

        // R9: aborted partial calibration
        pulse_start();
        for (int j = 0; j < 300; j++) send(7, 7, "R2 passthrough partial");

        // R7: uniform histogram
        for (int b = 0; b < 32; b++) hc[b] = TOTAL / 32;
        calibrate();
        for (int k = 0; k < 64; k++) begin
            send(k % 32, k % 32, "R7 identity");
            lf = lf_next(lf);
        end
        @(posedge clk);
        #1;
        chk(!out_valid, "R2 valid low in correction", int'(out_valid), 0);

        // wide code 0, empty code 1
        hc[0] = 64;
        hc[1] = 0;
        for (int b = 2; b < 32; b++) hc[b] = 32;
        calibrate();
        corr(1, "R8 empty code");
        chk(model(1, lf) == 2, "R8 empty code target", model(1, lf), 2);
        for (int b = 2; b < 32; b++) corr(b, "R8 single-bin code");
        begin
            int ones = 0;
            for (int j = 0; j < 128; j++) begin
                if (model(0, lf) == 1) ones++;
                corr(0, "R5 dithered code");
            end
            // R6: proportional spread over ideal bins 0 and 1
            chk(ones > 40 && ones < 88, "R6 dither share", ones, 64);
        end

        // narrow code 0, wide code 1
        hc[0] = 16;
        hc[1] = 48;
        calibrate();
        for (int j = 0; j < 16; j++) begin
            chk(model(0, lf) == 0, "R8 narrow code model", model(0, lf), 0);
            corr(0, "R8 narrow code");
            corr(1, "R5 wide code");
        end
        for (int b = 0; b < 32; b++) corr(b, "R4 R5 sweep");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule